// File: doc/BRIEF.md
# Variant-Screened Command Decoder

This block takes one 4-bit command token at a time from an upstream receiver and returns exactly one response for each one. The full command set is shared by every build of the chip. Each build implements only part of that set. An elaboration-time parameter, `VARIANT`, selects which part.

Every accepted token first passes through a screening stage. This stage keeps the token if the build supports it. Otherwise it substitutes a reserved "not implemented" token. The screened token is registered for one cycle and then decoded by a case statement. Each arm of that case drives the action strobe of its command. Because the mask is constant, command paths that a build lacks reduce to the default arm. Those commands still get an answer, with a "not supported" status.

The response carries a 2-bit status and the original token echoed back. It is offered on a valid/ready pair. Only one command is outstanding at a time: the block lowers `cmd_ready` from the accept cycle until the response has been taken.

Top module: `cmdv_decoder`

## Requirements
- R1: Tokens are 4 bits wide. Codes 0x0 to 0xB are defined commands, codes 0xC to 0xE are undefined, and 0xF is reserved as the internal "not implemented" marker.
- R2: The `VARIANT` parameter fixes the set of supported commands at elaboration. Value 0 supports all twelve codes, 1 supports codes 0x0 to 0x7, and 2 supports the even codes 0x0, 0x2, 0x4, 0x6, 0x8 and 0xA.
- R3: A supported token produces status 2'b00 (OK), and `resp_token` equals the received token.
- R4: A token that is defined but not supported by the variant produces status 2'b01 (not supported), with `resp_token` echoing the received token and no action strobe.
- R5: A token in the range 0xC to 0xF produces status 2'b01, with `resp_token` echoing the received token and no action strobe.
- R6: Each accepted command yields exactly one response. `cmd_ready` is low from the cycle after acceptance until the cycle after the response handshake.
- R7: If a command is accepted in cycle N, `resp_valid` is low in cycle N+1 and first high in cycle N+2.
- R8: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_status` and `resp_token` hold their values.
- R9: For an executed command k, `act_strobe` bit k is high for exactly one cycle, in the first cycle of its response. All other bits are zero, and all bits are zero in every other cycle.
- R10: The synchronous active-high reset clears the pending response, the pipeline stage and all action strobes.
- R11: `cmd_valid` asserted while `cmd_ready` is low is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command token is offered |
| cmd_ready | output | 1 | Block can accept a token |
| cmd_token | input | 4 | Command token |
| resp_valid | output | 1 | Response is available |
| resp_ready | input | 1 | Consumer takes the response |
| resp_status | output | 2 | 2'b00 OK, 2'b01 not supported |
| resp_token | output | 4 | Original token echoed |
| act_strobe | output | 12 | One-cycle action pulse per command |

## Verification
The bench works through all sixteen token values, both supported and unsupported, under variant 2. This exercises the boundary between defined and undefined codes and the reserved 0xF marker. A screen that let an unsupported code through would raise a stray strobe and report OK; one that lost the original token would echo 0xF. Random back-pressure on `resp_ready` checks that a stalled response does not change and that its strobe does not fire again. A design that re-pulsed on the hold or dropped the held data would fail there. Tokens offered while busy, and a reset in the middle of a command, show whether the block leaks extra responses or keeps stale state.

// File: rtl/cmdv_pkg.sv
package cmdv_pkg;

  localparam int TOK_W = 4;
  localparam int NCMD  = 12;

  typedef logic [TOK_W-1:0] tok_t;

  typedef enum logic [TOK_W-1:0] {
    CMD_IDLE   = 4'h0,
    CMD_PING   = 4'h1,
    CMD_RDID   = 4'h2,
    CMD_CLRCNT = 4'h3,
    CMD_ARM    = 4'h4,
    CMD_DISARM = 4'h5,
    CMD_TRIG   = 4'h6,
    CMD_LOAD   = 4'h7,
    CMD_STORE  = 4'h8,
    CMD_CAL    = 4'h9,
    CMD_SELFT  = 4'hA,
    CMD_SLEEP  = 4'hB,
    CMD_NIMP   = 4'hF
  } cmd_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_NSUP = 2'b01
  } status_e;

  // Supported-command mask for each build variant, fixed at elaboration.
  function automatic logic [NCMD-1:0] variant_mask(input int v);
    logic [NCMD-1:0] m;
    m = '0;
    for (int i = 0; i < NCMD; i++) begin
      case (v)
        1:       m[i] = (i < 8);
        2:       m[i] = ((i % 2) == 0);
        default: m[i] = 1'b1;
      endcase
    end
    return m;
  endfunction

  // Keep a token the mask supports; map everything else to the marker.
  function automatic tok_t prescreen(input tok_t t, input logic [NCMD-1:0] m);
    tok_t r;
    r = CMD_NIMP;
    for (int i = 0; i < NCMD; i++) begin
      if (t == tok_t'(i) && m[i]) r = t;
    end
    return r;
  endfunction

endpackage

// File: rtl/cmdv_screen.sv
module cmdv_screen
  import cmdv_pkg::*;
#(
  parameter logic [NCMD-1:0] MASK = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  tok_t tok_in,
  output logic s1_valid,
  output tok_t s1_scr,
  output tok_t s1_orig
);

  tok_t scr_c;
  assign scr_c = prescreen(tok_in, MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_scr   <= CMD_NIMP;
      s1_orig  <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_scr  <= scr_c;
        s1_orig <= tok_in;
      end
    end
  end

endmodule

// File: rtl/cmdv_decode.sv
module cmdv_decode
  import cmdv_pkg::*;
(
  input  tok_t            scr,
  output logic [NCMD-1:0] strobe,
  output status_e         status
);

  always_comb begin
    strobe = '0;
    status = ST_OK;
    case (cmd_e'(scr))
      CMD_IDLE:   strobe[0]  = 1'b1;
      CMD_PING:   strobe[1]  = 1'b1;
      CMD_RDID:   strobe[2]  = 1'b1;
      CMD_CLRCNT: strobe[3]  = 1'b1;
      CMD_ARM:    strobe[4]  = 1'b1;
      CMD_DISARM: strobe[5]  = 1'b1;
      CMD_TRIG:   strobe[6]  = 1'b1;
      CMD_LOAD:   strobe[7]  = 1'b1;
      CMD_STORE:  strobe[8]  = 1'b1;
      CMD_CAL:    strobe[9]  = 1'b1;
      CMD_SELFT:  strobe[10] = 1'b1;
      CMD_SLEEP:  strobe[11] = 1'b1;
      default:    status     = ST_NSUP;
    endcase
  end

endmodule

// File: rtl/cmdv_resp.sv
module cmdv_resp
  import cmdv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  status_e         st_in,
  input  tok_t            tok_in,
  input  logic [NCMD-1:0] strobe_in,
  input  logic            resp_ready,
  output logic            resp_valid,
  output logic [1:0]      resp_status,
  output tok_t            resp_token,
  output logic [NCMD-1:0] act_strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
      resp_token  <= '0;
      act_strobe  <= '0;
    end else begin
      act_strobe <= load ? strobe_in : '0;
      if (load) begin
        resp_valid  <= 1'b1;
        resp_status <= st_in;
        resp_token  <= tok_in;
      end else if (resp_valid && resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmdv_decoder.sv
module cmdv_decoder
  import cmdv_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_token,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [1:0]  resp_status,
  output logic [3:0]  resp_token,
  output logic [11:0] act_strobe
);

  localparam logic [NCMD-1:0] MASK = variant_mask(VARIANT);

  logic            take;
  logic            s1_valid;
  tok_t            s1_scr;
  tok_t            s1_orig;
  logic [NCMD-1:0] dec_strobe;
  status_e         dec_status;

  assign cmd_ready = !(s1_valid || resp_valid);
  assign take      = cmd_valid && cmd_ready;

  cmdv_screen #(.MASK(MASK)) u_screen (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .tok_in   (cmd_token),
    .s1_valid (s1_valid),
    .s1_scr   (s1_scr),
    .s1_orig  (s1_orig)
  );

  cmdv_decode u_decode (
    .scr    (s1_scr),
    .strobe (dec_strobe),
    .status (dec_status)
  );

  cmdv_resp u_resp (
    .clk         (clk),
    .rst         (rst),
    .load        (s1_valid),
    .st_in       (dec_status),
    .tok_in      (s1_orig),
    .strobe_in   (dec_strobe),
    .resp_ready  (resp_ready),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .resp_token  (resp_token),
    .act_strobe  (act_strobe)
  );

endmodule

// File: rtl/cmdv_decoder_chk.sv
module cmdv_decoder_chk
  import cmdv_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [1:0]  resp_status,
  input logic [3:0]  resp_token,
  input logic [11:0] act_strobe,
  input logic        s1_valid
);

  localparam logic [NCMD-1:0] CMASK = variant_mask(VARIANT);

  AST_STROBE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (act_strobe & ~CMASK) == '0);                                          // R2

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_strobe));                                                 // R9

  AST_STROBE_OK: assert property (@(posedge clk) disable iff (rst)
    (act_strobe != '0) |-> (resp_valid && resp_status == 2'b00
                            && act_strobe == (12'd1 << resp_token)));      // R3

  AST_NSUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 2'b01) |-> (act_strobe == '0));          // R4

  AST_UNDEF_NSUP: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_token >= 4'hC) |-> (resp_status == 2'b01));        // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!resp_valid && !s1_valid));                             // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (s1_valid && !resp_valid));               // R7

  AST_STAGE_TO_RESP: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> resp_valid);                                              // R7

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_status) && $stable(resp_token)));        // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!resp_valid && !s1_valid && act_strobe == '0));               // R10

endmodule

bind cmdv_decoder cmdv_decoder_chk #(.VARIANT(VARIANT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_status (resp_status),
  .resp_token  (resp_token),
  .act_strobe  (act_strobe),
  .s1_valid    (s1_valid)
);

// File: tb/cmdv_decoder_test.sv
module cmdv_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_token = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [1:0]  resp_status;
  logic [3:0]  resp_token;
  logic [11:0] act_strobe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmdv_decoder #(.VARIANT(2)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_token(cmd_token), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_status(resp_status), .resp_token(resp_token), .act_strobe(act_strobe)
  );

  // Variant 2: the even defined codes are supported.
  function automatic bit exp_supported(input logic [3:0] t);
    return (t < 4'hC) && (t[0] == 1'b0);
  endfunction

  function automatic logic [1:0] exp_status(input logic [3:0] t);
    return exp_supported(t) ? 2'b00 : 2'b01;
  endfunction

  function automatic logic [11:0] exp_strobe(input logic [3:0] t);
    return exp_supported(t) ? (12'd1 << t) : 12'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] t, input int hold, input bit junk);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R6 ready when idle", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_token = t;
    @(negedge clk);
    cmd_valid = junk;
    cmd_token = 4'($urandom);
    chk(resp_valid == 1'b0, "R7 no response one cycle after accept", int'(resp_valid), 0);
    chk(cmd_ready == 1'b0, "R6 busy after accept", int'(cmd_ready), 0);
    @(negedge clk);
    chk(resp_valid == 1'b1, "R7 response two cycles after accept", int'(resp_valid), 1);
    chk(resp_token == t, "R3 R4 R5 echoed token", int'(resp_token), int'(t));
    chk(resp_status == exp_status(t),
        exp_supported(t) ? "R3 status ok" : (t >= 4'hC ? "R5 undefined status" : "R4 unsupported status"),
        int'(resp_status), int'(exp_status(t)));
    chk(act_strobe == exp_strobe(t), "R9 strobe on first response cycle",
        int'(act_strobe), int'(exp_strobe(t)));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_token == t && resp_status == exp_status(t),
          "R8 response held", int'({resp_valid, resp_status, resp_token}),
          int'({1'b1, exp_status(t), t}));
      chk(act_strobe == 12'd0, "R9 strobe only once", int'(act_strobe), 0);
      chk(cmd_ready == 1'b0, "R6 busy while pending", int'(cmd_ready), 0);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    cmd_valid = 1'b0;
    chk(resp_valid == 1'b0, "R6 single response consumed", int'(resp_valid), 0);
    chk(cmd_ready == 1'b1, "R6 ready after handshake", int'(cmd_ready), 1);
    if (junk) begin
      @(negedge clk);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R11 busy-time token ignored", int'(resp_valid), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(resp_valid == 1'b0 && act_strobe == 12'd0, "R10 reset state",
        int'({resp_valid, act_strobe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 ready after reset", int'(cmd_ready), 1);

    // Directed sweep of every code: R1 R2 boundaries.
    for (int t = 0; t < 16; t++) send(4'(t), t % 3, (t % 4) == 1);

    // Random tokens with random back-pressure.
    for (int n = 0; n < 80; n++) send(4'($urandom_range(0, 15)), $urandom_range(0, 4), $urandom_range(0, 1) == 1);

    // Reset in the middle of a command.
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_token = 4'h4;
    @(negedge clk);
    cmd_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(resp_valid == 1'b0 && act_strobe == 12'd0, "R10 mid-command reset",
        int'({resp_valid, act_strobe}), 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R10 no response after reset", int'(resp_valid), 0);
    send(4'h6, 1, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule